// File: doc/BRIEF.md
# Programmable Chip-Select and Wait-State Unit

This block sits between a processor's 24-bit external bus and up to eight memory or peripheral banks. Each bank has its own chip-select line, which is active low. Every channel is set up through a small register write port. The settings per channel are:
- a 5-bit base that is compared with the top address bits, and a 4-bit mask that widens the bank from 512 KB to 8 MB;
- a wait-state count, or a mode that waits for an external acknowledge;
- the cycle direction it answers to;
- whether its select follows the address strobe or the data strobe;
- which byte lanes it serves.

A bus cycle begins when the address strobe falls. On the first clock edge that sees the strobe low (the accept edge), the block captures the address, direction and byte strobes. It picks the matching channel; when several match, the lowest-numbered one wins. It drives that channel's select and then produces a one-clock `ready` pulse after the programmed number of clocks. An access that breaks a channel's direction or byte-lane restriction never selects the bank. If the time-out enable is set, such an access ends in a one-clock `busErr` pulse after a fixed delay.

Channel 7 comes out of hardware reset with a boot preset: read-only, an 8 MB block at address zero, 6 wait states. All other channels stay off until they are written. A software reset aborts the current cycle and leaves every register unchanged.

Top module: `csUnit`

## Requirements
- R1: Register word layout, from LSB to MSB:
  - bits 4:0 are the base, compared with addr[23:19];
  - bits 8:5 are the mask, where bit 5+k set excludes addr[19+k] from the compare (k = 0..3);
  - bits 11:9 are the wait code;
  - bits 13:12 are the direction: 00 off, 01 read-only, 10 write-only, 11 both;
  - bit 14 is the strobe select: 0 address strobe, 1 data strobe;
  - bits 16:15 are the lanes: 01 low byte only, 10 high byte only, 11 or 00 word.

  Register addresses 0..7 are channels 0..7. Address 8 is the system register, with bit 0 the fast-cycle bit and bit 1 the time-out enable.
- R2: When several enabled channels match the captured address, only the lowest-numbered one drives its select low. At most one `csN` bit is low at any time.
- R3: For wait code w (0..6) on an unrestricted channel, `ready` is high during the (B+w)-th clock after the accept edge, where B is 1 with the fast-cycle bit set and 2 with it clear. This gives a bus cycle of 3+w or 4+w clocks.
- R4: Wait code 7 on an unrestricted channel keeps extending the cycle. `ready` is high in the first clock at or after clock B in which `ackN` is low. With `ackN` held low, this equals zero wait states.
- R5: A read on a write-only channel, or a write (`rdWr`=0) on a read-only channel, is a violation.
- R6: The selected channel's `csN` bit is low only while its chosen strobe (`asN` or `dsN`) is low during an active cycle.
- R7: With `ubN` low, a low-byte-only channel is in violation. With `lbN` low, a high-byte-only channel is in violation. Byte strobes are captured on the accept edge.
- R8: On a violation, no select goes low and no `ready` is given. If the time-out enable is 1, `busErr` is high during the 64th clock after the accept edge. If it is 0, `busErr` is never given. A restricted channel with wait code 7 uses 6 internal wait states.
- R9: After hardware reset, channel 7 holds base 0, mask 1111, wait code 6, read-only, address strobe, word lanes. All other channels and the system register are zero, so their selects stay high.
- R10: `swReset` ends the current cycle (selects high, no `ready`) and leaves all registers unchanged. A cycle whose address strobe is still low is not accepted again.
- R11: `ready` and `busErr` are single-clock pulses and are never high together.
- R12: A register write on the same edge as an accept takes effect from the next cycle. The accepted cycle uses the previous settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hardware reset, active low; loads the register presets |
| swReset | input | 1 | Software reset; aborts the cycle, keeps registers |
| addr | input | 24 | Bus address |
| rdWr | input | 1 | 1 = read, 0 = write |
| asN | input | 1 | Address strobe, active low |
| dsN | input | 1 | Data strobe, active low |
| ubN | input | 1 | Upper byte strobe, active low |
| lbN | input | 1 | Lower byte strobe, active low |
| ackN | input | 1 | External acknowledge, active low |
| regWe | input | 1 | Register write enable |
| regAddr | input | 4 | Register index (0..7 channels, 8 system) |
| regWdata | input | 17 | Register write data |
| csN | output | 8 | Chip selects, active low |
| ready | output | 1 | One-clock cycle-complete pulse |
| busErr | output | 1 | One-clock bus error pulse |

## Verification
Two things can land on one clock edge: a register write and the accept of a new bus cycle. The bench provokes this by writing channel 6 with a new base on exactly the edge that accepts a cycle to that address. It then judges the result in two steps:
- the accepted cycle must still go to the boot channel with its 6 wait states;
- the very next cycle to the same address must go to channel 6 with zero waits.

A second overlap comes from placing a software reset inside a running cycle. The select must rise and no `ready` may follow, and the next cycle must still show the programmed timing.

// File: rtl/csPkg.sv
package csPkg;

  localparam int BASEW = 5;  // address bits 23..19
  localparam int MASKW = 4;  // mask for bits 19..22

  typedef struct packed {
    logic [1:0]       lanes;  // 01 low only, 10 high only, else word
    logic             useDs;  // 1: select timed from data strobe
    logic [1:0]       dir;    // 00 off, 01 read, 10 write, 11 both
    logic [2:0]       waits;  // 0..6 internal, 7 wait for acknowledge
    logic [MASKW-1:0] mask;
    logic [BASEW-1:0] base;
  } chanCfgT;

  localparam int CFGW = $bits(chanCfgT);

  localparam chanCfgT BOOT_CFG = '{lanes: 2'b11, useDs: 1'b0, dir: 2'b01,
                                  waits: 3'd6, mask: 4'hF, base: 5'd0};

  // control -> datapath strobes
  typedef struct packed {
    logic accept;  // capture address and selection this edge
    logic active;  // a bus cycle is in progress
  } ctrlT;

  // datapath -> control: context of the captured cycle
  typedef struct packed {
    logic       hit;
    logic       viol;
    logic       ackMode;
    logic [2:0] waits;
  } cycInfoT;

endpackage

// File: rtl/csDatapath.sv
module csDatapath
  import csPkg::*;
#(
  parameter int NCH   = 8,
  parameter int ADDRW = 24,
  localparam int IW   = $clog2(NCH),
  localparam int RAW  = $clog2(NCH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             swReset,
  input  logic [ADDRW-1:0] addr,
  input  logic             rdWr,
  input  logic             asN,
  input  logic             dsN,
  input  logic             ubN,
  input  logic             lbN,
  input  logic             regWe,
  input  logic [RAW-1:0]   regAddr,
  input  logic [CFGW-1:0]  regWdata,
  input  ctrlT             ctl,
  output cycInfoT          info,
  output logic             fastBus,
  output logic             toEn,
  output logic [NCH-1:0]   csN
);

  chanCfgT [NCH-1:0] cfgQ;
  logic [1:0]        sysQ;
  logic [NCH-1:0]    match;
  logic              selHit;
  logic [IW-1:0]     selIdx;
  chanCfgT           sc;
  logic              restricted, violNow;
  logic              curHit, curViol, curAck, curDs;
  logic [2:0]        curWaits;
  logic [IW-1:0]     curIdx;
  logic              strobeLow;

  // register file: only hardware reset loads presets
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NCH; i++)
        cfgQ[i] <= (i == NCH - 1) ? BOOT_CFG : chanCfgT'('0);
      sysQ <= '0;
    end else if (regWe) begin
      for (int i = 0; i < NCH; i++)
        if (regAddr == RAW'(i)) cfgQ[i] <= chanCfgT'(regWdata);
      if (regAddr == RAW'(NCH)) sysQ <= regWdata[1:0];
    end
  end

  assign fastBus = sysQ[0];
  assign toEn    = sysQ[1];

  // per-channel address compare
  for (genvar g = 0; g < NCH; g++) begin : gMatch
    logic [BASEW-1:0] diff;
    assign diff     = addr[ADDRW-1 -: BASEW] ^ cfgQ[g].base;
    assign match[g] = (cfgQ[g].dir != 2'b00) &&
                      ((diff & {1'b1, ~cfgQ[g].mask}) == '0);
  end

  // lowest channel wins
  always_comb begin
    selHit = 1'b0;
    selIdx = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (match[i]) begin
        selHit = 1'b1;
        selIdx = IW'(i);
      end
  end

  assign sc         = cfgQ[selIdx];
  assign restricted = (sc.dir != 2'b11) || (sc.lanes == 2'b01) || (sc.lanes == 2'b10);
  assign violNow    = (sc.dir == 2'b01 && !rdWr) || (sc.dir == 2'b10 && rdWr) ||
                      (sc.lanes == 2'b01 && !ubN) || (sc.lanes == 2'b10 && !lbN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curHit   <= 1'b0;
      curViol  <= 1'b0;
      curAck   <= 1'b0;
      curDs    <= 1'b0;
      curWaits <= '0;
      curIdx   <= '0;
    end else if (ctl.accept) begin
      curHit   <= selHit;
      curViol  <= selHit && violNow;
      curAck   <= (sc.waits == 3'd7) && !restricted;
      curDs    <= sc.useDs;
      curWaits <= (sc.waits == 3'd7) ? (restricted ? 3'd6 : 3'd0) : sc.waits;
      curIdx   <= selIdx;
    end
  end

  assign info = '{hit: curHit, viol: curViol, ackMode: curAck, waits: curWaits};

  assign strobeLow = curDs ? !dsN : !asN;

  for (genvar g = 0; g < NCH; g++) begin : gSel
    assign csN[g] = !(ctl.active && curHit && !curViol &&
                      (curIdx == IW'(g)) && strobeLow);
  end

  // R2: never more than one select low
  a_r2_one_select: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  // R8: a violating cycle never selects a bank
  a_r8_viol_no_select: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.active && curViol) |-> (&csN));

  // R10: software reset leaves the registers unchanged
  a_r10_regs_kept: assert property (@(posedge clk) disable iff (!rstN)
    (swReset && !regWe) |=> $stable(cfgQ));

endmodule

// File: rtl/csControl.sv
module csControl
  import csPkg::*;
#(
  parameter int TIMEOUT = 64,
  localparam int CW     = $clog2(TIMEOUT + 1) + 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    swReset,
  input  logic    asN,
  input  logic    ackN,
  input  cycInfoT info,
  input  logic    fastBus,
  input  logic    toEn,
  output ctrlT    ctl,
  output logic    ready,
  output logic    busErr
);

  typedef enum logic [1:0] {IDLE, ACT, DONE} stateT;

  stateT         state;
  logic          asPrev;
  logic [CW-1:0] cnt;
  logic [CW-1:0] target;
  logic          accept;

  assign accept = (state == IDLE) && !asN && asPrev && !swReset;
  assign target = CW'(fastBus ? 1 : 2) + CW'(info.waits);

  assign ready  = (state == ACT) && info.hit && !info.viol && (cnt >= target) &&
                  (!info.ackMode || !ackN);
  assign busErr = (state == ACT) && info.hit && info.viol && toEn &&
                  (cnt == CW'(TIMEOUT));

  assign ctl = '{accept: accept, active: (state != IDLE)};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= IDLE;
      asPrev <= 1'b1;
      cnt    <= '0;
    end else begin
      asPrev <= asN;
      if (swReset) begin
        state <= IDLE;
        cnt   <= '0;
      end else begin
        case (state)
          IDLE: if (accept) begin
            state <= ACT;
            cnt   <= '0;
          end
          ACT: begin
            if (cnt != {CW{1'b1}}) cnt <= cnt + 1'b1;
            if (asN) state <= IDLE;
            else if (ready || busErr || !info.hit) state <= DONE;
          end
          DONE: if (asN) state <= IDLE;
          default: state <= IDLE;
        endcase
      end
    end
  end

  // R11: exclusive single-clock pulses
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(ready && busErr));
  a_r11_ready_pulse: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> !ready);
  a_r11_err_pulse: assert property (@(posedge clk) disable iff (!rstN)
    busErr |=> !busErr);

  // R10: software reset returns to idle
  a_r10_abort: assert property (@(posedge clk) disable iff (!rstN)
    swReset |=> (state == IDLE));

endmodule

// File: rtl/csUnit.sv
module csUnit
  import csPkg::*;
#(
  parameter int NCH     = 8,
  parameter int ADDRW   = 24,
  parameter int TIMEOUT = 64
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     swReset,
  input  logic [ADDRW-1:0]         addr,
  input  logic                     rdWr,
  input  logic                     asN,
  input  logic                     dsN,
  input  logic                     ubN,
  input  logic                     lbN,
  input  logic                     ackN,
  input  logic                     regWe,
  input  logic [$clog2(NCH+1)-1:0] regAddr,
  input  logic [CFGW-1:0]          regWdata,
  output logic [NCH-1:0]           csN,
  output logic                     ready,
  output logic                     busErr
);

  ctrlT    ctl;
  cycInfoT info;
  logic    fastBus, toEn;

  csDatapath #(.NCH(NCH), .ADDRW(ADDRW)) uDp (
    .clk(clk), .rstN(rstN), .swReset(swReset), .addr(addr), .rdWr(rdWr),
    .asN(asN), .dsN(dsN), .ubN(ubN), .lbN(lbN), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .ctl(ctl), .info(info),
    .fastBus(fastBus), .toEn(toEn), .csN(csN)
  );

  csControl #(.TIMEOUT(TIMEOUT)) uCtl (
    .clk(clk), .rstN(rstN), .swReset(swReset), .asN(asN), .ackN(ackN),
    .info(info), .fastBus(fastBus), .toEn(toEn), .ctl(ctl),
    .ready(ready), .busErr(busErr)
  );

endmodule

// File: tb/sim_csUnit.sv
module sim_csUnit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        swReset = 1'b0;
  logic [23:0] addr = '0;
  logic        rdWr = 1'b1;
  logic        asN = 1'b1, dsN = 1'b1, ubN = 1'b1, lbN = 1'b1, ackN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [16:0] regWdata = '0;
  logic [7:0]  csN;
  logic        ready, busErr;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;  // 125 MHz

  csUnit u0 (
    .clk(clk), .rstN(rstN), .swReset(swReset), .addr(addr), .rdWr(rdWr),
    .asN(asN), .dsN(dsN), .ubN(ubN), .lbN(lbN), .ackN(ackN), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .csN(csN), .ready(ready),
    .busErr(busErr)
  );

  // kinds: 0 ready, 1 bus error, 2 nothing; channel 8 = no select
  typedef struct packed {
    logic [23:0] a;
    logic        rd;
    logic        ub;
    logic        lb;
    logic [3:0]  ch;
    logic [1:0]  kind;
    logic [6:0]  lat;
  } vecT;

  localparam vecT VEC [12] = '{
    '{24'h100000, 1'b1, 1'b0, 1'b0, 4'd0, 2'd0, 7'd4},   // R1 R2 R3 ch0 wins over ch1
    '{24'h180000, 1'b1, 1'b0, 1'b0, 4'd1, 2'd0, 7'd2},   // R1 mask on bit 19
    '{24'h200000, 1'b1, 1'b0, 1'b0, 4'd2, 2'd0, 7'd2},   // R4 ack held low
    '{24'h300000, 1'b0, 1'b0, 1'b0, 4'd3, 2'd0, 7'd3},   // R5 write-only, write
    '{24'h300000, 1'b1, 1'b0, 1'b0, 4'd8, 2'd1, 7'd64},  // R5 R8 read on write-only
    '{24'h400000, 1'b1, 1'b1, 1'b0, 4'd4, 2'd0, 7'd5},   // R7 low byte ok
    '{24'h400000, 1'b1, 1'b0, 1'b0, 4'd8, 2'd1, 7'd64},  // R7 R8 word on low-only
    '{24'h500000, 1'b1, 1'b0, 1'b1, 4'd5, 2'd0, 7'd8},   // R8 code 7 restricted = 6
    '{24'h500000, 1'b1, 1'b1, 1'b0, 4'd8, 2'd1, 7'd64},  // R7 low lane on high-only
    '{24'h600000, 1'b1, 1'b0, 1'b0, 4'd7, 2'd0, 7'd8},   // R9 boot read
    '{24'h600000, 1'b0, 1'b0, 1'b0, 4'd8, 2'd1, 7'd64},  // R5 boot write
    '{24'h900000, 1'b1, 1'b0, 1'b0, 4'd8, 2'd2, 7'd0}    // R1 no channel
  };

  function automatic logic [16:0] mk(input logic [4:0] b, input logic [3:0] m,
                                     input logic [2:0] w, input logic [1:0] d,
                                     input logic ds, input logic [1:0] ln);
    return {ln, ds, d, w, m, b};
  endfunction

  function automatic int chOf(input logic [7:0] c);
    for (int i = 0; i < 8; i++) if (!c[i]) return i;
    return 8;
  endfunction

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic writeReg(input logic [3:0] a, input logic [16:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWe = 1'b0;
    @(negedge clk); #1;
  endtask

  task automatic endCycle();
    asN = 1'b1; dsN = 1'b1;
    @(negedge clk); @(negedge clk); #1;
  endtask

  task automatic runCycle(input logic [23:0] a, input logic rd, input logic ub,
                          input logic lb, output int ch, output int kind,
                          output int lat);
    addr = a; rdWr = rd; ubN = ub; lbN = lb; asN = 1'b0; dsN = 1'b0;
    @(posedge clk); #1;
    regWe = 1'b0;
    ch = 8; kind = 2; lat = 0;
    for (int k = 0; k < 70; k++) begin
      @(negedge clk); #1;
      if (k == 0) ch = chOf(csN);
      if (ready)  begin kind = 0; lat = k; break; end
      if (busErr) begin kind = 1; lat = k; break; end
    end
    endCycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int ch, kind, lat;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;

    // R9: reset state
    check(csN == 8'hFF, "R9 selects high after reset", int'(csN), 255);
    check(!ready && !busErr, "R11 no pulse after reset", int'(ready), 0);

    // R9: boot channel catches everything below 8 MB, others off
    runCycle(24'h000000, 1'b1, 1'b0, 1'b0, ch, kind, lat);
    check(ch == 7, "R9 boot channel select", ch, 7);
    check(kind == 0 && lat == 8, "R9 boot 6 waits slow", lat, 8);
    runCycle(24'h100000, 1'b1, 1'b0, 1'b0, ch, kind, lat);
    check(ch == 7, "R9 other channels off", ch, 7);
    // R8: write on read-only boot, time-out disabled at reset
    runCycle(24'h000000, 1'b0, 1'b0, 1'b0, ch, kind, lat);
    check(ch == 8 && kind == 2, "R8 no bus error when disabled", kind, 2);

    // program channels
    writeReg(4'd8, 17'b10);                                   // time-out on, slow
    writeReg(4'd0, mk(5'b00010, 4'b0000, 3'd2, 2'b11, 1'b0, 2'b11));
    writeReg(4'd1, mk(5'b00010, 4'b0001, 3'd0, 2'b11, 1'b0, 2'b11));
    writeReg(4'd2, mk(5'b00100, 4'b0000, 3'd7, 2'b11, 1'b1, 2'b11));
    writeReg(4'd3, mk(5'b00110, 4'b0000, 3'd1, 2'b10, 1'b0, 2'b11));
    writeReg(4'd4, mk(5'b01000, 4'b0000, 3'd3, 2'b11, 1'b0, 2'b01));
    writeReg(4'd5, mk(5'b01010, 4'b0000, 3'd7, 2'b11, 1'b0, 2'b10));

    foreach (VEC[i]) begin
      runCycle(VEC[i].a, VEC[i].rd, VEC[i].ub, VEC[i].lb, ch, kind, lat);
      check(ch == int'(VEC[i].ch), $sformatf("R1 R2 row %0d select", i), ch, int'(VEC[i].ch));
      check(kind == int'(VEC[i].kind), $sformatf("R3 R8 row %0d outcome", i), kind, int'(VEC[i].kind));
      if (VEC[i].kind != 2'd2)
        check(lat == int'(VEC[i].lat), $sformatf("R3 R4 row %0d latency", i), lat, int'(VEC[i].lat));
    end

    // R6 + R4: data-strobe timing and waiting for acknowledge
    ackN = 1'b1;
    addr = 24'h200000; rdWr = 1'b1; ubN = 1'b0; lbN = 1'b0; asN = 1'b0; dsN = 1'b1;
    @(posedge clk); @(negedge clk); #1;
    check(csN[2] == 1'b1, "R6 select waits for data strobe", int'(csN[2]), 1);
    dsN = 1'b0; #1;
    check(csN[2] == 1'b0, "R6 select follows data strobe", int'(csN[2]), 0);
    begin
      bit early = 0;
      for (int k = 1; k < 6; k++) begin
        @(negedge clk); #1;
        if (ready) early = 1;
      end
      check(!early, "R4 no ready while ack high", int'(early), 0);
    end
    ackN = 1'b0; #1;
    check(ready == 1'b1, "R4 ready when ack low", int'(ready), 1);
    endCycle();

    // R12: write coinciding with accept
    regWe = 1'b1; regAddr = 4'd6;
    regWdata = mk(5'b01100, 4'b0000, 3'd0, 2'b11, 1'b0, 2'b11);
    runCycle(24'h600000, 1'b1, 1'b0, 1'b0, ch, kind, lat);
    check(ch == 7 && lat == 8, "R12 accept uses old settings", ch * 100 + lat, 708);
    runCycle(24'h600000, 1'b1, 1'b0, 1'b0, ch, kind, lat);
    check(ch == 6 && lat == 2, "R12 new settings next cycle", ch * 100 + lat, 602);

    // R3: fast bus cycle
    writeReg(4'd8, 17'b11);
    runCycle(24'h180000, 1'b1, 1'b0, 1'b0, ch, kind, lat);
    check(kind == 0 && lat == 1, "R3 fast zero-wait cycle", lat, 1);
    runCycle(24'h100000, 1'b1, 1'b0, 1'b0, ch, kind, lat);
    check(kind == 0 && lat == 3, "R3 fast two waits", lat, 3);

    // R8: violation with time-out off
    writeReg(4'd8, 17'b01);
    runCycle(24'h300000, 1'b1, 1'b0, 1'b0, ch, kind, lat);
    check(ch == 8 && kind == 2, "R8 violation silent when disabled", kind, 2);

    // R10: software reset mid-cycle
    addr = 24'h100000; rdWr = 1'b1; asN = 1'b0; dsN = 1'b0;
    @(posedge clk); @(negedge clk); #1;
    check(csN == 8'hFE, "R10 ch0 selected before abort", int'(csN), 254);
    swReset = 1'b1;
    @(negedge clk); #1;
    swReset = 1'b0;
    begin
      bit sawReady = 0;
      bit sawSel = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk); #1;
        if (ready) sawReady = 1;
        if (csN != 8'hFF) sawSel = 1;
      end
      check(!sawReady && !sawSel, "R10 cycle aborted", int'(sawReady) + int'(sawSel), 0);
    end
    endCycle();
    runCycle(24'h100000, 1'b1, 1'b0, 1'b0, ch, kind, lat);
    check(ch == 0 && lat == 3, "R10 registers kept", ch * 100 + lat, 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule